// File: doc/BRIEF.md
# Key-Sequence Register Unlock Guard

This block keeps two small control registers behind key sequences. Each register has a lock bit that is set when reset ends. While the lock bit is set, software writes to the register's other fields have no effect. To clear the lock, software writes two fixed 32-bit key values, in order, to a key register that belongs to that control register.

A mistake in the sequence latches a frozen state that only reset clears. The mistake can be a wrong value, the second key sent first, or any key write while the register is already open. Software closes an open register again by writing 1 to its lock bit. That write leaves every other field as it was.

Two independent guard instances sit behind one write/read port. One guards the main control register and the other guards the option control register. Each has its own key pair, and a freeze on one has no effect on the other. The lock states and the field contents also come out as plain outputs for the logic that uses them.

Top module: `key_guard_regs`

## Requirements
- R1: After reset both lock outputs are 1, both field outputs are 0, and a read of either control address (addr 0 main, addr 2 option) returns 32'h0000_0001.
- R2: Writing KEY1 and then KEY2 to the key address of a guard (addr 1 for main, addr 3 for option), with no other key write between them, clears that guard's lock on the clock edge of the KEY2 write.
- R3: While a guard is locked, including between the KEY1 and KEY2 writes, a write to its control address leaves the field output unchanged.
- R4: A key write that does not continue a valid sequence (a value other than KEY1 as the first word, or a value other than KEY2 as the second) freezes the guard: its lock stays 1 and later correct sequences do not clear it.
- R5: Any key write to a guard that is open relocks it and freezes it as in R4.
- R6: Writing a control word with bit 0 = 1 to an open guard sets its lock and leaves the fields unchanged. A fresh KEY1 and KEY2 sequence opens it again.
- R7: Writing a control word with bit 0 = 0 to an open guard loads wdata bits 31:1 into the field output, and the guard stays open.
- R8: A read of a key address returns 0. A read of a control address returns the fields in bits 31:1 and the lock in bit 0, at all times.
- R9: The two guards are independent. Their default key pairs differ. A write to one guard's addresses, including a freezing one, changes nothing in the other guard.
- R10: Reset clears a frozen state, and afterwards the correct sequence unlocks the guard again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 2 | 0 main control, 1 main key, 2 option control, 3 option key |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| ctrl_lock_o | output | 1 | Main guard lock state |
| ctrl_fields_o | output | CTRL_FIELD_W | Main guarded fields |
| opt_lock_o | output | 1 | Option guard lock state |
| opt_fields_o | output | OPT_FIELD_W | Option guarded fields |

## Verification
The bench goes after the sequence edges.

- **Control write between KEY1 and KEY2.** A design that treated half a sequence as unlocking would let this write through.
- **KEY2 written first.** A design that only checked the last word would unlock here.
- **Repeated unlock while open.** A design that ignored key writes on an open guard would stay open.
- **Relock word carrying nonzero field bits.** A design that loaded fields on the relock write would corrupt the register.

Random episodes, with a reset between them, mix key values from both guards into both key addresses. This checks that a freeze on one guard never leaks into the other and that reset always clears the freeze.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_FROZEN = 2'd3
  } key_state_e;
endpackage

// File: rtl/key_seq_fsm.sv
module key_seq_fsm
  import keyguard_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2 = 32'hCDEF_89AB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_data_i,
  input  logic              relock_i,
  output logic              open_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (key_wr_i) state_d = (key_data_i == KEY1) ? KS_HALF : KS_FROZEN;
      KS_HALF:   if (key_wr_i) state_d = (key_data_i == KEY2) ? KS_OPEN : KS_FROZEN;
      KS_OPEN: begin
        if (key_wr_i)      state_d = KS_FROZEN;  // repeated unlock is a violation
        else if (relock_i) state_d = KS_LOCKED;
      end
      default:   state_d = KS_FROZEN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_LOCKED;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);
endmodule

// File: rtl/guarded_fields.sv
module guarded_fields #(
  parameter int FIELD_W = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               open_i,
  input  logic [FIELD_W:0]   wdata_i,
  output logic [FIELD_W-1:0] fields_o
);
  // bit 0 of the write is the lock request; fields load only on a plain write
  logic load;
  assign load = wr_i && open_i && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fields_o <= '0;
    else if (load) fields_o <= wdata_i[FIELD_W:1];
  end
endmodule

// File: rtl/key_guard_unit.sv
module key_guard_unit
  import keyguard_pkg::*;
#(
  parameter int                FIELD_W = 31,
  parameter logic [DATA_W-1:0] KEY1    = 32'h4567_0123,
  parameter logic [DATA_W-1:0] KEY2    = 32'hCDEF_89AB
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_wr_i,
  input  logic               key_wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               lock_o,
  output logic [FIELD_W-1:0] fields_o,
  output logic [DATA_W-1:0]  ctrl_rdata_o
);
  localparam int PAD_W = DATA_W - 1 - FIELD_W;

  logic open;

  key_seq_fsm #(.KEY1(KEY1), .KEY2(KEY2)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (key_wr_i),
    .key_data_i (wdata_i),
    .relock_i   (ctrl_wr_i && wdata_i[0]),
    .open_o     (open)
  );

  guarded_fields #(.FIELD_W(FIELD_W)) u_fields (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr_i),
    .open_i   (open),
    .wdata_i  (wdata_i[FIELD_W:0]),
    .fields_o (fields_o)
  );

  assign lock_o = !open;

  generate
    if (PAD_W > 0) begin : g_pad
      assign ctrl_rdata_o = {{PAD_W{1'b0}}, fields_o, lock_o};
    end else begin : g_full
      assign ctrl_rdata_o = {fields_o, lock_o};
    end
  endgenerate
endmodule

// File: rtl/key_guard_regs.sv
module key_guard_regs
  import keyguard_pkg::*;
#(
  parameter int                CTRL_FIELD_W = 31,
  parameter int                OPT_FIELD_W  = 31,
  parameter logic [DATA_W-1:0] CTRL_KEY1    = 32'h4567_0123,
  parameter logic [DATA_W-1:0] CTRL_KEY2    = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY1     = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OPT_KEY2     = 32'h4C5D_6E7F
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    ctrl_lock_o,
  output logic [CTRL_FIELD_W-1:0] ctrl_fields_o,
  output logic                    opt_lock_o,
  output logic [OPT_FIELD_W-1:0]  opt_fields_o
);
  // addr[1] picks the guard, addr[0] picks key (1) or control (0)
  logic [DATA_W-1:0] ctrl_rd, opt_rd;

  key_guard_unit #(.FIELD_W(CTRL_FIELD_W), .KEY1(CTRL_KEY1), .KEY2(CTRL_KEY2)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (wr_i && addr_i == 2'd0),
    .key_wr_i     (wr_i && addr_i == 2'd1),
    .wdata_i      (wdata_i),
    .lock_o       (ctrl_lock_o),
    .fields_o     (ctrl_fields_o),
    .ctrl_rdata_o (ctrl_rd)
  );

  key_guard_unit #(.FIELD_W(OPT_FIELD_W), .KEY1(OPT_KEY1), .KEY2(OPT_KEY2)) u_opt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr_i    (wr_i && addr_i == 2'd2),
    .key_wr_i     (wr_i && addr_i == 2'd3),
    .wdata_i      (wdata_i),
    .lock_o       (opt_lock_o),
    .fields_o     (opt_fields_o),
    .ctrl_rdata_o (opt_rd)
  );

  always_comb begin
    unique case (addr_i)
      2'd0:    rdata_o = ctrl_rd;
      2'd2:    rdata_o = opt_rd;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/keyguard_checker.sv
module keyguard_checker
  import keyguard_pkg::*;
#(
  parameter int                CTRL_FIELD_W = 31,
  parameter int                OPT_FIELD_W  = 31,
  parameter logic [DATA_W-1:0] CTRL_KEY2    = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY2     = 32'h4C5D_6E7F
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [DATA_W-1:0]       wdata_i,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    ctrl_lock_o,
  input logic [CTRL_FIELD_W-1:0] ctrl_fields_o,
  input logic                    opt_lock_o,
  input logic [OPT_FIELD_W-1:0]  opt_fields_o
);
  p_ctrl_unlock_needs_key2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_lock_o) |-> $past(wr_i && addr_i == 2'd1 && wdata_i == CTRL_KEY2));

  p_opt_unlock_needs_key2_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(opt_lock_o) |-> $past(wr_i && addr_i == 2'd3 && wdata_i == OPT_KEY2));

  p_ctrl_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_lock_o |=> $stable(ctrl_fields_o));

  p_opt_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_lock_o |=> $stable(opt_fields_o));

  p_relock_keeps_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_lock_o) |-> $stable(ctrl_fields_o));

  p_key_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[0] |-> rdata_o == '0);

  p_lock_visible_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 2'd0 |-> rdata_o[0] == ctrl_lock_o);

  p_ctrl_isolated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[1]) |=> $stable(ctrl_lock_o) && $stable(ctrl_fields_o));
endmodule

bind key_guard_regs keyguard_checker #(
  .CTRL_FIELD_W (CTRL_FIELD_W),
  .OPT_FIELD_W  (OPT_FIELD_W),
  .CTRL_KEY2    (CTRL_KEY2),
  .OPT_KEY2     (OPT_KEY2)
) u_chk (.*);

// File: tb/key_guard_regs_test.sv
module key_guard_regs_test;
  localparam logic [31:0] K1 [2] = '{32'h4567_0123, 32'h0819_2A3B};
  localparam logic [31:0] K2 [2] = '{32'hCDEF_89AB, 32'h4C5D_6E7F};

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        wr_i = 0;
  logic [1:0]  addr_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic        ctrl_lock_o, opt_lock_o;
  logic [30:0] ctrl_fields_o, opt_fields_o;

  key_guard_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .ctrl_lock_o(ctrl_lock_o), .ctrl_fields_o(ctrl_fields_o),
    .opt_lock_o(opt_lock_o), .opt_fields_o(opt_fields_o)
  );

  always #5 clk = ~clk;

  // model: 0 locked, 1 half, 2 open, 3 frozen
  int          st [2];
  logic [30:0] fm [2];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    if (a[0]) return 32'h0;
    return {fm[a[1]], st[a[1]] != 2};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 4; a++) begin
      addr_i = 2'(a);
      #1;
      chk(req, $sformatf("read addr %0d", a), rdata_o, exp_read(2'(a)));
    end
    chk(req, "ctrl_lock_o", {31'h0, ctrl_lock_o}, {31'h0, st[0] != 2});
    chk(req, "opt_lock_o", {31'h0, opt_lock_o}, {31'h0, st[1] != 2});
    chk(req, "ctrl_fields_o", {1'b0, ctrl_fields_o}, {1'b0, fm[0]});
    chk(req, "opt_fields_o", {1'b0, opt_fields_o}, {1'b0, fm[1]});
  endtask

  task automatic model_write(input logic [1:0] a, input logic [31:0] d);
    int u = a[1];
    if (a[0]) begin
      case (st[u])
        0: st[u] = (d == K1[u]) ? 1 : 3;
        1: st[u] = (d == K2[u]) ? 2 : 3;
        2: st[u] = 3;
        default: st[u] = 3;
      endcase
    end else if (st[u] == 2) begin
      if (d[0]) st[u] = 0;
      else fm[u] = d[31:1];
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 0;
    model_write(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    st = '{0, 0};
    fm = '{31'h0, 31'h0};
  endtask

  task automatic unlock(input int u);
    do_write({u[0], 1'b1}, K1[u]);
    do_write({u[0], 1'b1}, K2[u]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    check_all("R1");

    do_write(2'd0, 32'hFFFF_FFFE);
    check_all("R3");
    do_write(2'd1, K1[0]);
    do_write(2'd0, 32'h0000_1234);
    check_all("R3");
    do_write(2'd1, K2[0]);
    check_all("R2");

    do_write(2'd0, 32'hA5A5_5A5A);
    check_all("R7");
    do_write(2'd0, 32'hFFFF_FFFF);
    check_all("R6");
    unlock(0);
    check_all("R6");
    check_all("R9");
    check_all("R8");

    do_write(2'd1, K1[0]);
    check_all("R5");
    unlock(0);
    do_write(2'd0, 32'h0000_0F00);
    check_all("R5");

    do_reset();
    check_all("R10");
    unlock(0);
    check_all("R10");

    do_write(2'd3, K2[1]);
    unlock(1);
    check_all("R4");
    do_write(2'd0, 32'h0000_0040);
    check_all("R9");

    do_reset();
    do_write(2'd3, 32'hDEAD_BEEF);
    do_write(2'd3, K1[1]);
    check_all("R4");
    do_write(2'd3, K1[0]);
    check_all("R9");

    for (int ep = 0; ep < 60; ep++) begin
      do_reset();
      for (int n = 0; n < 25; n++) begin
        logic [1:0]  a = 2'($urandom % 4);
        logic [31:0] d;
        int r = $urandom % 10;
        int u = $urandom % 2;
        if (a[0]) d = (r < 4) ? K1[u] : (r < 8) ? K2[u] : $urandom;
        else      d = {$urandom, 1'b0} | ((r < 2) ? 32'h1 : 32'h0);
        do_write(a, d);
        check_all(a[0] ? "R4" : "R7");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule